// File: doc/BRIEF.md
# Tag-Based Reservation Station Scheduler

This block is the scheduling core of a dynamically scheduled processor that renames registers by producer tags. Decoded instructions arrive one at a time in program order. Each one names a target execution unit (ALU or memory), a destination register and two source registers. The register file data path sits outside the block, so the source register values arrive with the instruction. A register status table records, for every architectural register, the tag of the station slot that will write it next. Tag zero means that no write is pending.

Each execution unit has its own station pool. A slot's tag identifies both the unit and the slot, so every in-flight result has a distinct name. A source whose register carries a nonzero tag is held as that tag until a broadcast with the same tag is seen on the single shared result bus. Slots whose operands are all present are sent to their unit oldest first. The block also decides which unit drives the result bus. Memory beats the ALU, and a unit that loses keeps its result and takes no new work in that cycle.

Top module: `rs_scheduler`

## Requirements
- R1: An accepted instruction takes the lowest-numbered free slot of its target unit (iss_unit 0 = ALU, 1 = memory). The slot's tag is unit*DEPTH + slot + 1, so with DEPTH 4 the ALU tags are 1..4 and the memory tags are 5..8. Tag 0 is reserved for "no pending producer".
- R2: A source whose register has tag 0 at issue takes its value from iss_val_a / iss_val_b.
- R3: At issue, the destination register's tag becomes the tag of the allocated slot. Later readers of that register wait on this tag.
- R4: A waiting source captures cdb_data when cdb_valid is high with a matching cdb_tag. The slot can dispatch from the next cycle on.
- R5: A source that carries a tag equal to the tag broadcast in the issue cycle captures the bus value at issue and does not wait.
- R6: A broadcast returns every register holding that tag to 0, except a register that is the destination of an issue in the same cycle, which keeps the new tag.
- R7: At most one unit drives the result bus per cycle. When both request, the memory unit is granted, and cdb_tag/cdb_data equal the winner's res_tag/res_data.
- R8: A unit that requests the bus and is not granted gets no dispatch in that cycle.
- R9: A unit with fu_busy high gets no dispatch.
- R10: Among the ready slots of one unit, the one issued earliest is dispatched first, whatever its slot number.
- R11: iss_stall is high when iss_valid is high and the target unit has no free slot. The stalled instruction is dropped and changes no state. The other unit keeps accepting.
- R12: A slot stays occupied from issue until its own tag is broadcast, including after it has dispatched.
- R13: After reset every slot is free, every register tag is 0, and no dispatch or broadcast is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Decoded instruction present |
| iss_unit | input | 1 | Target unit: 0 ALU, 1 memory |
| iss_op | input | OPW | Operation code passed to the unit |
| iss_dst | input | RW | Destination register |
| iss_src_a | input | RW | First source register |
| iss_src_b | input | RW | Second source register |
| iss_val_a | input | DW | Register file value of first source |
| iss_val_b | input | DW | Register file value of second source |
| iss_stall | output | 1 | Target station full, instruction not taken |
| fu_busy | input | 2 | Unit cannot take an instruction |
| disp_valid | output | 2 | Dispatch to unit, one bit per unit |
| disp_op | output | 2*OPW | Dispatched operation per unit |
| disp_a | output | 2*DW | Dispatched first operand per unit |
| disp_b | output | 2*DW | Dispatched second operand per unit |
| disp_tag | output | 2*TAGW | Tag the unit must broadcast with |
| res_req | input | 2 | Unit holds a finished result |
| res_tag | input | 2*TAGW | Tag of each held result |
| res_data | input | 2*DW | Value of each held result |
| res_grant | output | 2 | Unit wins the result bus this cycle |
| cdb_valid | output | 1 | Result bus carries a broadcast |
| cdb_tag | output | TAGW | Broadcast tag |
| cdb_data | output | DW | Broadcast value |

## Verification
A corrupted register tag appears at the ports a few cycles later. A younger reader then dispatches with the stale value from the issue port when it should have waited, or it waits on a broadcast that never comes, and its dispatch is missing in the cycle the tags predict. A wrong age matrix shows up at the first dispatch where the ready slots' slot order differs from their issue order. A slot released early shows up as a missing iss_stall, or as a duplicated tag on a later dispatch. Bus priority and the hold of the losing unit show up at once, in the cycle both units request.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NUNITS   = 2;
  localparam int UNIT_ALU = 0;
  localparam int UNIT_MEM = 1;
  localparam int UNIT_W   = 1;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_HELD = 2'd1,
    SLOT_EXEC = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rs_tag_table.sv
module rs_tag_table #(
  parameter int RW   = 5,
  parameter int TAGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RW-1:0]   rd_a,
  input  logic [RW-1:0]   rd_b,
  output logic [TAGW-1:0] tag_a,
  output logic [TAGW-1:0] tag_b,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_reg,
  input  logic [TAGW-1:0] wr_tag,
  input  logic            bc_valid,
  input  logic [TAGW-1:0] bc_tag
);
  localparam int NREGS = 1 << RW;

  logic [TAGW-1:0] tag_q [NREGS];
  logic [TAGW-1:0] tag_n [NREGS];

  assign tag_a = tag_q[rd_a];
  assign tag_b = tag_q[rd_b];

  always_comb begin : next_tags
    for (int r = 0; r < NREGS; r++) begin
      tag_n[r] = tag_q[r];
      if (wr_en && wr_reg == RW'(r))
        tag_n[r] = wr_tag;
      else if (bc_valid && bc_tag != '0 && tag_q[r] == bc_tag)
        tag_n[r] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin : tag_regs
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) tag_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREGS; r++) tag_q[r] <= tag_n[r];
    end
  end

  // R3: destination takes the allocated slot tag
  p_retag_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tag_q[$past(wr_reg)] == $past(wr_tag));

  // R6: a matching broadcast without a same-cycle retag clears the register
  p_bc_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_tag != '0 && tag_q[rd_a] == bc_tag && !(wr_en && wr_reg == rd_a))
    |=> tag_q[$past(rd_a)] == '0);
endmodule

// File: rtl/rs_station.sv
module rs_station
  import sched_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OPW   = 4,
  parameter int DEPTH = 4,
  parameter int TAGW  = 4,
  parameter int BASE  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  logic [OPW-1:0]  alloc_op,
  input  logic [TAGW-1:0] a_tag,
  input  logic [DW-1:0]   a_val,
  input  logic [TAGW-1:0] b_tag,
  input  logic [DW-1:0]   b_val,
  input  logic            bc_valid,
  input  logic [TAGW-1:0] bc_tag,
  input  logic [DW-1:0]   bc_data,
  input  logic            accept,
  output logic            full,
  output logic [TAGW-1:0] alloc_tag,
  output logic            disp_valid,
  output logic [OPW-1:0]  disp_op,
  output logic [DW-1:0]   disp_a,
  output logic [DW-1:0]   disp_b,
  output logic [TAGW-1:0] disp_tag
);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  slot_state_e     st_q [DEPTH];
  slot_state_e     st_n [DEPTH];
  logic [OPW-1:0]  op_q [DEPTH];
  logic [OPW-1:0]  op_n [DEPTH];
  logic [TAGW-1:0] ta_q [DEPTH];
  logic [TAGW-1:0] ta_n [DEPTH];
  logic [TAGW-1:0] tb_q [DEPTH];
  logic [TAGW-1:0] tb_n [DEPTH];
  logic [DW-1:0]   va_q [DEPTH];
  logic [DW-1:0]   va_n [DEPTH];
  logic [DW-1:0]   vb_q [DEPTH];
  logic [DW-1:0]   vb_n [DEPTH];
  logic [DEPTH-1:0] older_q [DEPTH];
  logic [DEPTH-1:0] older_n [DEPTH];
  logic [DEPTH-1:0] pay_en;
  logic [DEPTH-1:0] free_v;
  logic [DEPTH-1:0] rdy_v;
  logic [DEPTH-1:0] pick_v;
  logic [SW-1:0]    free_idx;

  function automatic logic [TAGW-1:0] slot_tag(input int idx);
    return TAGW'(BASE + idx);
  endfunction

  always_comb begin : slot_flags
    for (int i = 0; i < DEPTH; i++) begin
      free_v[i] = (st_q[i] == SLOT_FREE);
      rdy_v[i]  = (st_q[i] == SLOT_HELD) && (ta_q[i] == '0) && (tb_q[i] == '0);
    end
  end

  always_comb begin : lowest_free
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (free_v[i]) free_idx = SW'(i);
  end

  assign full      = ~|free_v;
  assign alloc_tag = slot_tag(int'(free_idx));

  // a ready slot is picked when no older slot is ready
  always_comb begin : oldest_ready
    for (int i = 0; i < DEPTH; i++) begin
      pick_v[i] = rdy_v[i];
      for (int j = 0; j < DEPTH; j++)
        if (rdy_v[j] && older_q[j][i]) pick_v[i] = 1'b0;
    end
  end

  assign disp_valid = accept && (|pick_v);

  always_comb begin : disp_mux
    disp_op  = '0;
    disp_a   = '0;
    disp_b   = '0;
    disp_tag = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (pick_v[i]) begin
        disp_op  = disp_op  | op_q[i];
        disp_a   = disp_a   | va_q[i];
        disp_b   = disp_b   | vb_q[i];
        disp_tag = disp_tag | slot_tag(i);
      end
    end
  end

  always_comb begin : next_slots
    for (int i = 0; i < DEPTH; i++) begin
      st_n[i]    = st_q[i];
      op_n[i]    = op_q[i];
      ta_n[i]    = ta_q[i];
      tb_n[i]    = tb_q[i];
      va_n[i]    = va_q[i];
      vb_n[i]    = vb_q[i];
      older_n[i] = older_q[i];
      pay_en[i]  = 1'b0;
      if (st_q[i] == SLOT_HELD) begin
        if (bc_valid && ta_q[i] != '0 && ta_q[i] == bc_tag) begin
          ta_n[i]   = '0;
          va_n[i]   = bc_data;
          pay_en[i] = 1'b1;
        end
        if (bc_valid && tb_q[i] != '0 && tb_q[i] == bc_tag) begin
          tb_n[i]   = '0;
          vb_n[i]   = bc_data;
          pay_en[i] = 1'b1;
        end
        if (disp_valid && pick_v[i]) st_n[i] = SLOT_EXEC;
      end
      if (st_q[i] == SLOT_EXEC && bc_valid && bc_tag == slot_tag(i))
        st_n[i] = SLOT_FREE;
    end
    if (alloc) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == int'(free_idx)) begin
          st_n[i]    = SLOT_HELD;
          op_n[i]    = alloc_op;
          ta_n[i]    = a_tag;
          tb_n[i]    = b_tag;
          va_n[i]    = a_val;
          vb_n[i]    = b_val;
          older_n[i] = '0;
          pay_en[i]  = 1'b1;
        end else begin
          older_n[i][free_idx] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin : slot_regs
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]    <= SLOT_FREE;
        older_q[i] <= '0;
        op_q[i]    <= '0;
        ta_q[i]    <= '0;
        tb_q[i]    <= '0;
        va_q[i]    <= '0;
        vb_q[i]    <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]    <= st_n[i];
        older_q[i] <= older_n[i];
        if (pay_en[i]) begin
          op_q[i] <= op_n[i];
          ta_q[i] <= ta_n[i];
          tb_q[i] <= tb_n[i];
          va_q[i] <= va_n[i];
          vb_q[i] <= vb_n[i];
        end
      end
    end
  end

  // R11: the issue side never allocates into a full pool
  p_alloc_not_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);

  // R12: a dispatched slot is still occupied one cycle later
  p_disp_keeps_slot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> $countones(free_v) <= $past($countones(free_v)) + 1);
endmodule

// File: rtl/rs_cdb_arbiter.sv
module rs_cdb_arbiter
  import sched_pkg::*;
#(
  parameter int DW   = 32,
  parameter int TAGW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUNITS-1:0]      res_req,
  input  logic [NUNITS*TAGW-1:0] res_tag,
  input  logic [NUNITS*DW-1:0]   res_data,
  output logic [NUNITS-1:0]      res_grant,
  output logic                   cdb_valid,
  output logic [TAGW-1:0]        cdb_tag,
  output logic [DW-1:0]          cdb_data
);
  // higher unit index wins; the memory unit has the highest index
  always_comb begin : fixed_priority
    res_grant = '0;
    cdb_valid = 1'b0;
    cdb_tag   = '0;
    cdb_data  = '0;
    for (int u = 0; u < NUNITS; u++) begin
      if (res_req[u]) begin
        res_grant    = '0;
        res_grant[u] = 1'b1;
        cdb_valid    = 1'b1;
        cdb_tag      = res_tag[u*TAGW +: TAGW];
        cdb_data     = res_data[u*DW +: DW];
      end
    end
  end

  // R7: one driver at most, memory first
  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_grant));
  p_mem_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_req[UNIT_MEM] |-> (res_grant[UNIT_MEM] && cdb_tag == res_tag[UNIT_MEM*TAGW +: TAGW]));
endmodule

// File: rtl/rs_scheduler.sv
module rs_scheduler
  import sched_pkg::*;
#(
  parameter int DW    = 32,
  parameter int RW    = 5,
  parameter int OPW   = 4,
  parameter int DEPTH = 4,
  localparam int TAGW = $clog2(NUNITS * DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   iss_valid,
  input  logic [UNIT_W-1:0]      iss_unit,
  input  logic [OPW-1:0]         iss_op,
  input  logic [RW-1:0]          iss_dst,
  input  logic [RW-1:0]          iss_src_a,
  input  logic [RW-1:0]          iss_src_b,
  input  logic [DW-1:0]          iss_val_a,
  input  logic [DW-1:0]          iss_val_b,
  output logic                   iss_stall,
  input  logic [NUNITS-1:0]      fu_busy,
  output logic [NUNITS-1:0]      disp_valid,
  output logic [NUNITS*OPW-1:0]  disp_op,
  output logic [NUNITS*DW-1:0]   disp_a,
  output logic [NUNITS*DW-1:0]   disp_b,
  output logic [NUNITS*TAGW-1:0] disp_tag,
  input  logic [NUNITS-1:0]      res_req,
  input  logic [NUNITS*TAGW-1:0] res_tag,
  input  logic [NUNITS*DW-1:0]   res_data,
  output logic [NUNITS-1:0]      res_grant,
  output logic                   cdb_valid,
  output logic [TAGW-1:0]        cdb_tag,
  output logic [DW-1:0]          cdb_data
);
  logic [TAGW-1:0]   src_tag_a, src_tag_b;
  logic [TAGW-1:0]   eff_tag_a, eff_tag_b;
  logic [DW-1:0]     eff_val_a, eff_val_b;
  logic [NUNITS-1:0] full_u, alloc_u, accept_u;
  logic [TAGW-1:0]   alloc_tag_u [NUNITS];
  logic              iss_take;

  rs_cdb_arbiter #(.DW(DW), .TAGW(TAGW)) i_arb (
    .clk(clk), .rst_n(rst_n),
    .res_req(res_req), .res_tag(res_tag), .res_data(res_data),
    .res_grant(res_grant),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  assign iss_stall = iss_valid && full_u[iss_unit];
  assign iss_take  = iss_valid && !full_u[iss_unit];

  rs_tag_table #(.RW(RW), .TAGW(TAGW)) i_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_a(iss_src_a), .rd_b(iss_src_b),
    .tag_a(src_tag_a), .tag_b(src_tag_b),
    .wr_en(iss_take), .wr_reg(iss_dst), .wr_tag(alloc_tag_u[iss_unit]),
    .bc_valid(cdb_valid), .bc_tag(cdb_tag)
  );

  // operand resolution at issue, including a same-cycle broadcast
  always_comb begin : resolve_sources
    eff_tag_a = src_tag_a;
    eff_val_a = iss_val_a;
    if (src_tag_a != '0) begin
      eff_val_a = '0;
      if (cdb_valid && cdb_tag == src_tag_a) begin
        eff_tag_a = '0;
        eff_val_a = cdb_data;
      end
    end
    eff_tag_b = src_tag_b;
    eff_val_b = iss_val_b;
    if (src_tag_b != '0) begin
      eff_val_b = '0;
      if (cdb_valid && cdb_tag == src_tag_b) begin
        eff_tag_b = '0;
        eff_val_b = cdb_data;
      end
    end
  end

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    assign alloc_u[u]  = iss_take && (iss_unit == UNIT_W'(u));
    assign accept_u[u] = !fu_busy[u] && !(res_req[u] && !res_grant[u]);

    rs_station #(
      .DW(DW), .OPW(OPW), .DEPTH(DEPTH), .TAGW(TAGW), .BASE(u * DEPTH + 1)
    ) i_station (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_u[u]), .alloc_op(iss_op),
      .a_tag(eff_tag_a), .a_val(eff_val_a),
      .b_tag(eff_tag_b), .b_val(eff_val_b),
      .bc_valid(cdb_valid), .bc_tag(cdb_tag), .bc_data(cdb_data),
      .accept(accept_u[u]),
      .full(full_u[u]), .alloc_tag(alloc_tag_u[u]),
      .disp_valid(disp_valid[u]),
      .disp_op(disp_op[u*OPW +: OPW]),
      .disp_a(disp_a[u*DW +: DW]),
      .disp_b(disp_b[u*DW +: DW]),
      .disp_tag(disp_tag[u*TAGW +: TAGW])
    );

    // R9: a busy unit receives nothing
    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fu_busy[u] |-> !disp_valid[u]);
  end

  // R8: the ALU loses when both request and then takes no work
  p_loser_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_req[UNIT_ALU] && res_req[UNIT_MEM]) |-> !disp_valid[UNIT_ALU]);
endmodule

// File: tb/test_rs_scheduler.sv
module test_rs_scheduler;
  localparam int PERIOD = 10;
  localparam int DW = 32, RW = 5, OPW = 4, DEPTH = 4, TAGW = 4, NV = 26;

  typedef struct packed {
    logic iv; logic un; logic [4:0] dst; logic [4:0] sa; logic [4:0] sb;
    logic [31:0] va; logic [31:0] vb; logic [1:0] busy; logic [1:0] req;
    logic [3:0] t0; logic [31:0] d0; logic [3:0] t1; logic [31:0] d1;
    logic es; logic [1:0] edv;
    logic [3:0] et0; logic [31:0] ea0; logic [31:0] eb0;
    logic [3:0] et1; logic [31:0] ea1; logic [31:0] eb1;
    logic ecv; logic [3:0] ect; logic [31:0] ecd;
  } vec_t;

  // columns: issue | busy req res0 res1 | stall dv disp0 disp1 | cdb
  localparam vec_t VEC [NV] = '{
    '{1,1,5,4,0,100,0,     0,0,0,0,0,0,   0,0,0,0,0,0,0,0,    0,0,0},   // R1 mem load -> tag5
    '{1,0,3,2,5,7,'hEE,    0,0,0,0,0,0,   0,2,0,0,0,5,100,0,  0,0,0},   // R2 R3 waits on 5
    '{1,0,1,3,2,'hEE,7,    2,0,0,0,0,0,   0,0,0,0,0,0,0,0,    0,0,0},   // R3 waits on 1
    '{1,0,4,4,2,100,7,     2,0,0,0,0,0,   0,0,0,0,0,0,0,0,    0,0,0},   // R2 ready, tag3
    '{1,0,13,2,2,7,7,      2,0,0,0,0,0,   0,1,3,100,7,0,0,0,  0,0,0},   // R1 tag4
    '{0,0,0,0,0,0,0,       0,3,3,107,5,42,0,0,0,0,0,0,0,0,    1,5,42},  // R7 R8 alu loses
    '{0,0,0,0,0,0,0,       0,1,3,107,0,0, 0,1,1,7,42,0,0,0,   1,3,107}, // R4 R10
    '{0,0,0,0,0,0,0,       0,1,1,49,0,0,  0,1,4,7,7,0,0,0,    1,1,49},
    '{0,0,0,0,0,0,0,       0,0,0,0,0,0,   0,1,2,49,7,0,0,0,   0,0,0},   // R4
    '{0,0,0,0,0,0,0,       0,1,4,14,0,0,  0,0,0,0,0,0,0,0,    1,4,14},
    '{1,0,1,1,2,'hEE,7,    0,1,2,56,0,0,  0,0,0,0,0,0,0,0,    1,2,56},  // R5 R6
    '{1,0,8,1,2,'hEE,7,    0,0,0,0,0,0,   0,1,1,56,7,0,0,0,   0,0,0},   // R6 r1 keeps tag1
    '{0,0,0,0,0,0,0,       0,1,1,63,0,0,  0,0,0,0,0,0,0,0,    1,1,63},
    '{0,0,0,0,0,0,0,       0,0,0,0,0,0,   0,1,2,63,7,0,0,0,   0,0,0},   // R6
    '{1,0,9,2,2,7,7,       1,0,0,0,0,0,   0,0,0,0,0,0,0,0,    0,0,0},   // R9 busy
    '{1,0,10,2,2,1,2,      1,1,2,70,0,0,  0,0,0,0,0,0,0,0,    1,2,70},  // R9
    '{1,0,11,2,2,3,4,      1,0,0,0,0,0,   0,0,0,0,0,0,0,0,    0,0,0},   // R1 slot1 reused
    '{0,0,0,0,0,0,0,       0,0,0,0,0,0,   0,1,1,7,7,0,0,0,    0,0,0},   // R10
    '{0,0,0,0,0,0,0,       0,0,0,0,0,0,   0,1,3,1,2,0,0,0,    0,0,0},   // R10 older slot2
    '{0,0,0,0,0,0,0,       0,0,0,0,0,0,   0,1,2,3,4,0,0,0,    0,0,0},
    '{1,0,12,2,2,5,6,      0,0,0,0,0,0,   0,0,0,0,0,0,0,0,    0,0,0},   // R12 slots held
    '{1,0,14,2,2,'hEE,'hEE,0,0,0,0,0,0,   1,1,4,5,6,0,0,0,    0,0,0},   // R11 full
    '{1,1,15,2,2,8,9,      0,0,0,0,0,0,   0,0,0,0,0,0,0,0,    0,0,0},   // R11 other unit
    '{0,0,0,0,0,0,0,       0,0,0,0,0,0,   0,2,0,0,0,5,8,9,    0,0,0},   // R11 nothing dropped in
    '{1,1,16,5,3,11,12,    0,0,0,0,0,0,   0,0,0,0,0,0,0,0,    0,0,0},   // R6 cleared regs
    '{0,0,0,0,0,0,0,       0,0,0,0,0,0,   0,2,0,0,0,6,11,12,  0,0,0}
  };

  logic clk, rst_n;
  logic iss_valid, iss_unit, iss_stall;
  logic [OPW-1:0] iss_op;
  logic [RW-1:0] iss_dst, iss_src_a, iss_src_b;
  logic [DW-1:0] iss_val_a, iss_val_b;
  logic [1:0] fu_busy, disp_valid, res_req, res_grant;
  logic [2*OPW-1:0] disp_op;
  logic [2*DW-1:0] disp_a, disp_b, res_data;
  logic [2*TAGW-1:0] disp_tag, res_tag;
  logic cdb_valid;
  logic [TAGW-1:0] cdb_tag;
  logic [DW-1:0] cdb_data;
  int n_chk, n_bad;
  logic done;

  rs_scheduler #(.DW(DW), .RW(RW), .OPW(OPW), .DEPTH(DEPTH)) i_rs_scheduler (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_unit(iss_unit), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_val_a(iss_val_a), .iss_val_b(iss_val_b), .iss_stall(iss_stall),
    .fu_busy(fu_busy), .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag),
    .res_req(res_req), .res_tag(res_tag), .res_data(res_data),
    .res_grant(res_grant), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_data(cdb_data)
  );

  initial clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    iss_valid = 0; iss_unit = 0; iss_op = 0; iss_dst = 0; iss_src_a = 0; iss_src_b = 0;
    iss_val_a = 0; iss_val_b = 0; fu_busy = 0; res_req = 0; res_tag = 0; res_data = 0;
  endtask

  task automatic check_quiet(input string req);
    check(req, "disp_valid", 64'(disp_valid), 64'd0);
    check(req, "cdb_valid", 64'(cdb_valid), 64'd0);
  endtask

  initial begin : watchdog
    done = 1'b0;
    #(PERIOD * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    n_chk = 0; n_bad = 0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R13: empty after reset, an ALU issue is not stalled
    iss_valid = 1'b1;
    #1;
    check("R13", "iss_stall", 64'(iss_stall), 64'd0);
    check_quiet("R13");
    iss_valid = 1'b0;

    for (int k = 0; k < NV; k++) begin
      @(posedge clk);
      #1;
      iss_valid = VEC[k].iv; iss_unit = VEC[k].un; iss_op = OPW'(k);
      iss_dst = VEC[k].dst; iss_src_a = VEC[k].sa; iss_src_b = VEC[k].sb;
      iss_val_a = VEC[k].va; iss_val_b = VEC[k].vb;
      fu_busy = VEC[k].busy; res_req = VEC[k].req;
      res_tag = {VEC[k].t1, VEC[k].t0}; res_data = {VEC[k].d1, VEC[k].d0};
      @(negedge clk);
      check("R11", $sformatf("row %0d iss_stall", k), 64'(iss_stall), 64'(VEC[k].es));
      check("R8", $sformatf("row %0d disp_valid", k), 64'(disp_valid), 64'(VEC[k].edv));
      if (VEC[k].edv[0])
        check("R10", $sformatf("row %0d alu dispatch tag/a/b", k),
              {24'd0, disp_tag[3:0], disp_a[31:0], 4'd0},
              {24'd0, VEC[k].et0, VEC[k].ea0, 4'd0});
      if (VEC[k].edv[0])
        check("R4", $sformatf("row %0d alu operand b", k), 64'(disp_b[31:0]), 64'(VEC[k].eb0));
      if (VEC[k].edv[1])
        check("R1", $sformatf("row %0d mem dispatch tag/a/b", k),
              {disp_tag[7:4], disp_a[63:32], disp_b[59:32]},
              {VEC[k].et1, VEC[k].ea1, VEC[k].eb1[27:0]});
      check("R7", $sformatf("row %0d cdb_valid", k), 64'(cdb_valid), 64'(VEC[k].ecv));
      if (VEC[k].ecv)
        check("R7", $sformatf("row %0d cdb tag/data", k), {28'd0, cdb_tag, cdb_data},
              {28'd0, VEC[k].ect, VEC[k].ecd});
    end

    // R13: reset in the middle of a run frees the full ALU pool
    @(posedge clk);
    #1 idle_inputs();
    rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    iss_valid = 1'b1; iss_unit = 1'b0;
    @(negedge clk);
    check("R13", "iss_stall after mid-run reset", 64'(iss_stall), 64'd0);
    check_quiet("R13");
    // R2: register tags are cleared too: issued source values come out unchanged
    iss_dst = 5'd20; iss_src_a = 5'd1; iss_src_b = 5'd5; iss_val_a = 32'h31; iss_val_b = 32'h32;
    @(posedge clk);
    #1 idle_inputs();
    @(negedge clk);
    check("R2", "dispatch after reset", {disp_a[31:0], disp_b[31:0]}, {32'h31, 32'h32});
    check("R1", "first tag after reset", 64'(disp_tag[3:0]), 64'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule